// File: doc/BRIEF.md
# PPS Generator with Time-of-Day Clock

This block keeps wall-clock time inside one reference-clock domain. A sub-second counter counts reference-clock cycles (125,000,000 per second by default) and wraps once per second. On each wrap it advances a 40-bit seconds counter and raises a one-pulse-per-second output for a programmable number of cycles. The current seconds and cycles are exported as a timecode. Two software flags travel with the pulse and the timecode and say whether each can be trusted.

Software drives the block through a small 32-bit register port with single-cycle writes and combinational reads. The port gives access to a control word (clear, run, adjust, load and pulse width), the live counters, a set of staged time values, and an external-sync word. The staged values serve two purposes. A load copies them straight into the counters. An adjust adds them to the running time, with the carry from cycles into seconds handled. An external-sync request arms the block to wait for the next rising edge on a pulse-per-second input and then zero the sub-second counter on that edge.

Top module: `pps_rtc_core`

## Requirements
- R1: After rst_n is released, both counters, pps_o, pps_valid_o, tc_valid_o and the control and external-sync readbacks are all zero.
- R2: While the run bit (control bit 1) is 1, the cycle counter rises by one on every clock. While it is 0, both counters hold.
- R3: The cycle counter wraps from CYC_PER_SEC-1 to 0, and the seconds counter increments on that wrap. The seconds counter is SEC_W (40) bits wide and wraps modulo 2^40.
- R4: pps_o rises in the first cycle in which a natural wrap shows the cycle counter at 0. It stays high for exactly the pulse width given in control bits 31:4. A width of 0 gives no pulse.
- R5: Writing the control word with bit 0 set clears both counters at that clock edge, and this takes priority over a load in the same write. Writing bit 0 as 0 leaves the counters alone.
- R6: Writing the control word with bit 3 set loads the counters from the staged values at that clock edge.
- R7: Writing the control word with bit 2 set makes control bit 2 read 1 for one cycle. At the next edge the staged values are added to the counters, and a sum of CYC_PER_SEC or more subtracts one second from the cycles and adds one to the seconds. Bit 2 then reads 0.
- R8: Writing the external-sync word with bit 0 set arms a resync, and bit 0 then reads 0. The input passes through two flip-flops. On the third clock edge after ext_pps_in rises, the cycle counter is forced to 0 and bit 0 reads 1. Rising edges while not armed have no effect.
- R9: External-sync bit 1 drives pps_valid_o and bit 2 drives tc_valid_o. A write with bit 0 clear does not re-arm the resync.
- R10: The word addresses are: 0 for control, 1 for external sync, 2 for cycles, 3 for seconds bits 31:0, 4 for seconds bits 39:32, 5 for staged cycles, 6 for staged seconds 31:0 and 7 for staged seconds 39:32. The control word reads back as width, 0, adjust-busy, run, 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Write strobe for one cycle |
| reg_addr | input | 3 | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data at reg_addr |
| ext_pps_in | input | 1 | External pulse-per-second input (asynchronous) |
| pps_o | output | 1 | Generated pulse-per-second |
| pps_valid_o | output | 1 | Software flag: pps_o is trustworthy |
| tc_sec_o | output | SEC_W | Timecode seconds |
| tc_cyc_o | output | CYC_W | Timecode sub-second cycles |
| tc_valid_o | output | 1 | Software flag: timecode is trustworthy |

## Verification
The adjust arithmetic is tested with a table of load-then-adjust pairs. The pairs cover a plain sum, a cycle sum that carries into the seconds, a carry that ripples from the low seconds word into the high word, a full 40-bit seconds wrap, and a negative seconds offset that cancels the carry. This separates a missing carry, a wrong subtraction and a truncated seconds width. Free-running tests count edges across a rollover to confirm the wrap point and the exact pulse width, and separately that a zero width gives no pulse. The resync test counts the edges after ext_pps_in rises while armed, and repeats the edge while unarmed to show that it is ignored.

// File: rtl/pps_rtc_pkg.sv
// Shared register addresses and bit positions for the PPS / time-of-day block.
package pps_rtc_pkg;
    localparam int REG_AW = 3;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL      = 3'd0,
        A_XSYNC     = 3'd1,
        A_CYC       = 3'd2,
        A_SECLO     = 3'd3,
        A_SECHI     = 3'd4,
        A_STG_CYC   = 3'd5,
        A_STG_SECLO = 3'd6,
        A_STG_SECHI = 3'd7
    } reg_addr_e;

    // control word bits
    localparam int CB_CLR    = 0;
    localparam int CB_RUN    = 1;
    localparam int CB_ADJ    = 2;
    localparam int CB_LOAD   = 3;
    localparam int CB_PW_LSB = 4;
    localparam int PW_W      = 32 - CB_PW_LSB;

    // external-sync word bits
    localparam int XB_ARM  = 0;
    localparam int XB_PPSV = 1;
    localparam int XB_TCV  = 2;
endpackage

// File: rtl/pps_rtc_regs.sv
// Register file: decodes single-cycle writes, holds control and staged values,
// and muxes readback. Assumes SEC_W lies between 33 and 64.
module pps_rtc_regs
    import pps_rtc_pkg::*;
#(
    parameter int CYC_W = 28,
    parameter int SEC_W = 40
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    addr,
    input  logic [31:0]          wdata,
    output logic [31:0]          rdata,
    input  logic [CYC_W-1:0]     cyc,
    input  logic [SEC_W-1:0]     sec,
    input  logic                 sync_done,
    output logic                 run,
    output logic [PW_W-1:0]      width,
    output logic [CYC_W-1:0]     stg_cyc,
    output logic [SEC_W-1:0]     stg_sec,
    output logic                 clr_stb,
    output logic                 load_stb,
    output logic                 adj_busy,
    output logic                 arm_stb,
    output logic                 pps_valid,
    output logic                 tc_valid
);
    localparam int HI_W = SEC_W - 32;

    logic ctrl_wr, xs_wr;

    // address decode of the write strobe
    assign ctrl_wr  = wr_en && (addr == A_CTRL);
    assign xs_wr    = wr_en && (addr == A_XSYNC);
    assign clr_stb  = ctrl_wr && wdata[CB_CLR];
    assign load_stb = ctrl_wr && wdata[CB_LOAD];
    assign arm_stb  = xs_wr && wdata[XB_ARM];

    // control and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run       <= 1'b0;
            width     <= '0;
            adj_busy  <= 1'b0;
            pps_valid <= 1'b0;
            tc_valid  <= 1'b0;
        end else begin
            adj_busy <= ctrl_wr && wdata[CB_ADJ];
            if (ctrl_wr) begin
                run   <= wdata[CB_RUN];
                width <= wdata[31:CB_PW_LSB];
            end
            if (xs_wr) begin
                pps_valid <= wdata[XB_PPSV];
                tc_valid  <= wdata[XB_TCV];
            end
        end
    end

    // staged time values used by load and adjust
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_cyc <= '0;
            stg_sec <= '0;
        end else if (wr_en) begin
            case (addr)
                A_STG_CYC:   stg_cyc            <= wdata[CYC_W-1:0];
                A_STG_SECLO: stg_sec[31:0]      <= wdata;
                A_STG_SECHI: stg_sec[SEC_W-1:32] <= wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    // readback mux
    always_comb begin
        case (addr)
            A_CTRL:      rdata = {width, 1'b0, adj_busy, run, 1'b0};
            A_XSYNC:     rdata = {29'd0, tc_valid, pps_valid, sync_done};
            A_CYC:       rdata = 32'(cyc);
            A_SECLO:     rdata = sec[31:0];
            A_SECHI:     rdata = 32'(sec[SEC_W-1:32]);
            A_STG_CYC:   rdata = 32'(stg_cyc);
            A_STG_SECLO: rdata = stg_sec[31:0];
            A_STG_SECHI: rdata = 32'(stg_sec[SEC_W-1:32]);
            default:     rdata = '0;
        endcase
    end
endmodule

// File: rtl/pps_rtc_count.sv
// Time-of-day counters. Priority per edge: clear, load, adjust, realign, tick.
// Assumes the staged cycle value is below CYC_PER_SEC.
module pps_rtc_count #(
    parameter int CYC_W       = 28,
    parameter int SEC_W       = 40,
    parameter int CYC_PER_SEC = 125_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr_stb,
    input  logic             load_stb,
    input  logic             adj_go,
    input  logic             realign,
    input  logic [CYC_W-1:0] stg_cyc,
    input  logic [SEC_W-1:0] stg_sec,
    output logic [CYC_W-1:0] cyc,
    output logic [SEC_W-1:0] sec,
    output logic             wrap
);
    localparam logic [CYC_W-1:0] LAST  = CYC_W'(CYC_PER_SEC - 1);
    localparam logic [CYC_W:0]   LIM_X = (CYC_W+1)'(CYC_PER_SEC);

    logic [CYC_W:0]   sum_x;
    logic             carry;
    logic [CYC_W-1:0] adj_cyc;
    logic [SEC_W-1:0] adj_sec;

    // adjust arithmetic with cycle-to-second carry
    always_comb begin
        sum_x   = {1'b0, cyc} + {1'b0, stg_cyc};
        carry   = (sum_x >= LIM_X);
        adj_cyc = carry ? CYC_W'(sum_x - LIM_X) : sum_x[CYC_W-1:0];
        adj_sec = sec + stg_sec + SEC_W'(carry);
    end

    // natural rollover: only when nothing of higher priority acts
    assign wrap = run && !clr_stb && !load_stb && !adj_go && !realign && (cyc == LAST);

    // counter update
    always_ff @(posedge clk) begin
        if (!rst_n || clr_stb) begin
            cyc <= '0;
            sec <= '0;
        end else if (load_stb) begin
            cyc <= stg_cyc;
            sec <= stg_sec;
        end else if (adj_go) begin
            cyc <= adj_cyc;
            sec <= adj_sec;
        end else if (realign) begin
            cyc <= '0;
        end else if (wrap) begin
            cyc <= '0;
            sec <= sec + 1'b1;
        end else if (run) begin
            cyc <= cyc + 1'b1;
        end
    end
endmodule

// File: rtl/pps_rtc_pulse.sv
// Pulse stretcher: loads the width on a rollover and stays high while it counts down.
module pps_rtc_pulse #(
    parameter int PW_W = 28
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wrap,
    input  logic [PW_W-1:0] width,
    output logic            pps
);
    logic [PW_W-1:0] remain;

    // remaining high cycles of the current pulse
    always_ff @(posedge clk) begin
        if (!rst_n)          remain <= '0;
        else if (wrap)       remain <= width;
        else if (remain != 0) remain <= remain - 1'b1;
    end

    assign pps = (remain != 0);
endmodule

// File: rtl/pps_rtc_xsync.sv
// External pulse capture: two-flop synchroniser, rising-edge detect and arm/done state.
// Assumes ext_in is asynchronous to clk.
module pps_rtc_xsync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic arm_stb,
    output logic realign,
    output logic done
);
    logic meta, sync, prev, armed;

    // synchroniser and edge history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= 1'b0;
            sync <= 1'b0;
            prev <= 1'b0;
        end else begin
            meta <= ext_in;
            sync <= meta;
            prev <= sync;
        end
    end

    assign realign = armed && sync && !prev;

    // arm on request, finish on the first captured edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            done  <= 1'b0;
        end else if (arm_stb) begin
            armed <= 1'b1;
            done  <= 1'b0;
        end else if (realign) begin
            armed <= 1'b0;
            done  <= 1'b1;
        end
    end
endmodule

// File: rtl/pps_rtc_core.sv
// Top level: PPS generator and time-of-day clock in one reference-clock domain.
// Assumes register writes arrive synchronous to clk.
module pps_rtc_core
    import pps_rtc_pkg::*;
#(
    parameter int CYC_W       = 28,
    parameter int SEC_W       = 40,
    parameter int CYC_PER_SEC = 125_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ext_pps_in,
    output logic              pps_o,
    output logic              pps_valid_o,
    output logic [SEC_W-1:0]  tc_sec_o,
    output logic [CYC_W-1:0]  tc_cyc_o,
    output logic              tc_valid_o
);
    logic             run, clr_stb, load_stb, adj_busy, arm_stb;
    logic             realign, sync_done, wrap;
    logic [PW_W-1:0]  width;
    logic [CYC_W-1:0] stg_cyc, cyc;
    logic [SEC_W-1:0] stg_sec, sec;

    pps_rtc_regs #(.CYC_W(CYC_W), .SEC_W(SEC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .cyc(cyc), .sec(sec),
        .sync_done(sync_done), .run(run), .width(width), .stg_cyc(stg_cyc),
        .stg_sec(stg_sec), .clr_stb(clr_stb), .load_stb(load_stb),
        .adj_busy(adj_busy), .arm_stb(arm_stb), .pps_valid(pps_valid_o),
        .tc_valid(tc_valid_o)
    );

    pps_rtc_count #(.CYC_W(CYC_W), .SEC_W(SEC_W), .CYC_PER_SEC(CYC_PER_SEC)) u_count (
        .clk(clk), .rst_n(rst_n), .run(run), .clr_stb(clr_stb),
        .load_stb(load_stb), .adj_go(adj_busy), .realign(realign),
        .stg_cyc(stg_cyc), .stg_sec(stg_sec), .cyc(cyc), .sec(sec), .wrap(wrap)
    );

    pps_rtc_pulse #(.PW_W(PW_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .wrap(wrap), .width(width), .pps(pps_o)
    );

    pps_rtc_xsync u_xsync (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_pps_in), .arm_stb(arm_stb),
        .realign(realign), .done(sync_done)
    );

    assign tc_sec_o = sec;
    assign tc_cyc_o = cyc;
endmodule

// File: rtl/pps_rtc_checks.sv
// Assertion checker bound into pps_rtc_core; observes counter, pulse and sync signals.
module pps_rtc_checks #(
    parameter int CYC_W = 28,
    parameter int SEC_W = 40,
    parameter int PW_W  = 28
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic             clr_stb,
    input logic             load_stb,
    input logic             adj_busy,
    input logic             realign,
    input logic             wrap,
    input logic             pps,
    input logic [PW_W-1:0]  width,
    input logic [CYC_W-1:0] stg_cyc,
    input logic [SEC_W-1:0] stg_sec,
    input logic [CYC_W-1:0] cyc,
    input logic [SEC_W-1:0] sec
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr_stb && !load_stb && !adj_busy && !realign) |=> ($stable(cyc) && $stable(sec)));

    p_rollover_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cyc == '0 && sec == SEC_W'($past(sec) + 1'b1)));

    p_pulse_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && width != '0) |=> pps);

    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> (cyc == '0 && sec == '0));

    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !clr_stb) |=> (cyc == $past(stg_cyc) && sec == $past(stg_sec)));

    p_realign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (realign && !clr_stb && !load_stb && !adj_busy) |=> (cyc == '0));
endmodule

bind pps_rtc_core pps_rtc_checks #(.CYC_W(CYC_W), .SEC_W(SEC_W), .PW_W(pps_rtc_pkg::PW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .run(run), .clr_stb(clr_stb), .load_stb(load_stb),
    .adj_busy(adj_busy), .realign(realign), .wrap(wrap), .pps(pps_o),
    .width(width), .stg_cyc(stg_cyc), .stg_sec(stg_sec), .cyc(cyc), .sec(sec)
);

// File: tb/pps_rtc_core_test.sv
module pps_rtc_core_test;
    localparam int CPS = 16;
    localparam logic [31:0] RUN = 32'h2, ADJ = 32'h4, LOAD = 32'h8, CLR = 32'h1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ext_pps_in = 1'b0;
    logic        pps_o, pps_valid_o, tc_valid_o;
    logic [39:0] tc_sec_o;
    logic [27:0] tc_cyc_o;
    int checks = 0, failures = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    pps_rtc_core #(.CYC_PER_SEC(CPS)) uut (.*);

    // load / adjust vectors: staged load, staged offset, expected result
    localparam logic [27:0] V_LC [5] = '{28'd3, 28'd12, 28'd15, 28'd0, 28'd8};
    localparam logic [39:0] V_LS [5] = '{40'd10, 40'd100, 40'h00FFFFFFFF, 40'hFFFFFFFFFF, 40'd7};
    localparam logic [27:0] V_AC [5] = '{28'd4, 28'd9, 28'd1, 28'd0, 28'd8};
    localparam logic [39:0] V_AS [5] = '{40'd5, 40'd0, 40'd0, 40'd1, 40'hFFFFFFFFFF};
    localparam logic [27:0] V_EC [5] = '{28'd7, 28'd5, 28'd0, 28'd0, 28'd0};
    localparam logic [39:0] V_ES [5] = '{40'd15, 40'd101, 40'h0100000000, 40'd0, 40'd7};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic stage(input logic [27:0] c, input logic [39:0] s);
        wr(3'd5, 32'(c)); wr(3'd6, s[31:0]); wr(3'd7, 32'(s[39:32]));
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        logic [31:0] r;
        logic [27:0] held;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 cyc", 64'(tc_cyc_o), 0);
        chk("R1 sec", 64'(tc_sec_o), 0);
        chk("R1 pps", 64'(pps_o), 0);
        chk("R1 valid", 64'({pps_valid_o, tc_valid_o}), 0);
        rd(3'd0, r); chk("R1 ctrl", 64'(r), 0);
        rd(3'd1, r); chk("R1 xsync", 64'(r), 0);

        // R6 R7 R10 vector walk with the counter stopped
        for (int i = 0; i < 5; i++) begin
            stage(V_LC[i], V_LS[i]);
            wr(3'd0, LOAD | (32'd3 << 4));
            chk("R6 load cyc", 64'(tc_cyc_o), 64'(V_LC[i]));
            chk("R6 load sec", 64'(tc_sec_o), 64'(V_LS[i]));
            stage(V_AC[i], V_AS[i]);
            wr(3'd0, ADJ | (32'd3 << 4));
            rd(3'd0, r); chk("R7 busy", 64'(r[2]), 1);
            chk("R7 pending", 64'(tc_cyc_o), 64'(V_LC[i]));
            step(1);
            rd(3'd0, r); chk("R7 done", 64'(r[2]), 0);
            chk("R7 cyc", 64'(tc_cyc_o), 64'(V_EC[i]));
            chk("R7 sec", 64'(tc_sec_o), 64'(V_ES[i]));
            rd(3'd2, r); chk("R10 cyc rd", 64'(r), 64'(V_EC[i]));
            rd(3'd3, r); chk("R10 seclo rd", 64'(r), 64'(V_ES[i][31:0]));
            rd(3'd4, r); chk("R10 sechi rd", 64'(r), 64'(V_ES[i][39:32]));
        end

        // R5 clear beats load; clear bit 0 does nothing
        wr(3'd0, CLR | LOAD);
        chk("R5 clear cyc", 64'(tc_cyc_o), 0);
        chk("R5 clear sec", 64'(tc_sec_o), 0);
        stage(28'd9, 40'd3);
        wr(3'd0, LOAD);
        wr(3'd0, 32'd0);
        chk("R5 no clear cyc", 64'(tc_cyc_o), 9);
        chk("R5 no clear sec", 64'(tc_sec_o), 3);

        // R2 R3 R4 free run through one rollover, width 3
        stage(28'd0, 40'd0);
        wr(3'd0, LOAD);
        wr(3'd0, RUN | (32'd3 << 4));
        chk("R2 start", 64'(tc_cyc_o), 0);
        step(5);
        chk("R2 count", 64'(tc_cyc_o), 5);
        step(10);
        chk("R3 last", 64'(tc_cyc_o), 15);
        chk("R4 low before", 64'(pps_o), 0);
        step(1);
        chk("R3 wrap cyc", 64'(tc_cyc_o), 0);
        chk("R3 wrap sec", 64'(tc_sec_o), 1);
        chk("R4 rise", 64'(pps_o), 1);
        step(2);
        chk("R4 still high", 64'(pps_o), 1);
        step(1);
        chk("R4 width end", 64'(pps_o), 0);
        wr(3'd0, 32'd3 << 4);
        held = tc_cyc_o;
        step(4);
        chk("R2 hold", 64'(tc_cyc_o), 64'(held));
        rd(3'd0, r); chk("R10 ctrl rd", 64'(r), 64'(32'd3 << 4));

        // R4 width zero gives no pulse
        stage(28'd14, 40'd0);
        wr(3'd0, LOAD);
        wr(3'd0, RUN);
        for (int k = 0; k < 4; k++) begin
            step(1);
            chk("R4 zero width", 64'(pps_o), 0);
            if (k == 1) chk("R3 wrap w0", 64'(tc_cyc_o), 0);
        end
        wr(3'd0, 32'd0);

        // R8 armed resync and R9 flags
        stage(28'd7, 40'd0);
        wr(3'd0, LOAD);
        wr(3'd1, 32'h7);
        rd(3'd1, r); chk("R8 waiting", 64'(r[0]), 0);
        chk("R9 pps valid", 64'(pps_valid_o), 1);
        chk("R9 tc valid", 64'(tc_valid_o), 1);
        ext_pps_in = 1'b1;
        step(2);
        chk("R8 not yet", 64'(tc_cyc_o), 7);
        step(1);
        chk("R8 realigned", 64'(tc_cyc_o), 0);
        rd(3'd1, r); chk("R8 done", 64'(r[0]), 1);
        ext_pps_in = 1'b0;
        step(3);
        stage(28'd5, 40'd0);
        wr(3'd0, LOAD);
        ext_pps_in = 1'b1;
        step(4);
        chk("R8 unarmed ignored", 64'(tc_cyc_o), 5);
        wr(3'd1, 32'h2);
        chk("R9 only pps", 64'({pps_valid_o, tc_valid_o}), 2'b10);
        rd(3'd1, r); chk("R9 no rearm", 64'(r[0]), 1);
        wr(3'd1, 32'h4);
        chk("R9 only tc", 64'({pps_valid_o, tc_valid_o}), 2'b01);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule